// File: doc/BRIEF.md
# PC Card configuration register bank

This block is the attribute-memory side of a removable storage card that uses the PC Card or CompactFlash signalling. A byte-wide attribute bus reaches four configuration registers at even offsets above a base address: option, configuration status, pin replacement and socket/copy. Reads below the base return bytes of the card information structure, which arrives as a flat input vector, or zero past its length. Reads are combinational from the address. Writes take effect at the rising clock edge.

The block also produces the slot interrupt line. It combines the attached drive's interrupt level with the interrupt-disable and soft-reset bits of the device-control register. The task-file decoder writes those two bits into this block. A soft reset requested from either the option register or device control clears all card state and sends a one-cycle reset pulse to the drive logic.

Top module: `pcc_cfg_bank`

## Requirements
- R1: Option sits at BASE+0, status at BASE+2, pin replacement at BASE+4 and socket/copy at BASE+6. A read at any other address at or above BASE, odd ones included, returns 0x00, and a write there changes no state.
- R2: A read at address A below BASE returns byte A of the card information vector (bits 8A+7..8A) when A < CIS_LEN, and 0x00 otherwise. Writes below BASE change no state.
- R3: A write to option stores the value ANDed with 0xCF. It is read back one cycle later.
- R4: A status write keeps the current bits under mask 0x82 and takes bits under mask 0x74 from the value. A status read returns the register with bit 0x02 forced to 0 while the stored interrupt-disable bit is 1.
- R5: A status write whose bit 0x04 differs from the stored bit 0x04 sets the ready bit 0x20 of the pin register.
- R6: A pin-replacement read returns (pins AND 0x20) OR 0x0C. A pin write keeps the ready bit and takes bit 0x02 from the value, and it cannot set the ready bit itself.
- R7: The socket/copy register always reads 0x00 and ignores writes.
- R8: Status bit 0x02 takes the drive interrupt level at every clock edge. slot_irq_o is 1 only when status bit 0x02 is 0, the interrupt-disable and soft-reset device-control bits are 0, and option bit 0x80 is 0.
- R9: Asynchronous reset, an option write with bit 0x80 set, or a device-control write with devctl_srst_i set clears option, status, pins and interrupt-disable to 0 at the edge. A soft reset also drives drive_rst_o high for exactly the following cycle.
- R10: A device-control write without soft reset stores devctl_nien_i as the interrupt-disable bit. That bit gates slot_irq_o and masks the status read.
- R11: When a status write and a change of the drive interrupt level meet at one edge, bit 0x02 follows the drive level. When an option write and a device-control write meet at one edge, both are stored, unless either requests soft reset, in which case reset wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| attr_addr_i | input | AW | Attribute-space byte address |
| attr_wdata_i | input | 8 | Attribute write data |
| attr_we_i | input | 1 | Attribute write strobe, one cycle per write |
| attr_rdata_o | output | 8 | Attribute read data for attr_addr_i |
| cis_rom_i | input | CIS_LEN*8 | Card information bytes, byte 0 in the low bits |
| devctl_we_i | input | 1 | Device-control write strobe from the task-file decoder |
| devctl_nien_i | input | 1 | Written interrupt-disable bit (device-control bit 0x02) |
| devctl_srst_i | input | 1 | Written soft-reset bit (device-control bit 0x04) |
| drive_irq_i | input | 1 | Drive interrupt request level |
| slot_irq_o | output | 1 | Slot interrupt line |
| drive_rst_o | output | 1 | One-cycle reset pulse to the drive |

## Verification
The attribute bus and the drive interrupt level both feed status bit 0x02. The bench provokes this by raising or lowering drive_irq_i on the same edge as a status write, and it expects the drive level to win in the read-back. The option register and device control can also be written in one cycle. The bench judges this through the option read-back, the interrupt masking and the drive reset pulse, both with and without a reset bit in either write.

// File: rtl/pcc_cfg_pkg.sv
package pcc_cfg_pkg;
  typedef enum logic [2:0] {
    SEL_NONE, SEL_CIS, SEL_OPT, SEL_STAT, SEL_PINS, SEL_SOCK
  } attr_sel_e;

  localparam int OFF_OPT  = 0;
  localparam int OFF_STAT = 2;
  localparam int OFF_PINS = 4;
  localparam int OFF_SOCK = 6;

  localparam logic [7:0] OPT_WR_MASK  = 8'hCF;
  localparam logic [7:0] STAT_KEEP    = 8'h82;
  localparam logic [7:0] STAT_WR_MASK = 8'h74;
  localparam logic [7:0] PIN_KEEP     = 8'h20;
  localparam logic [7:0] PIN_WR_MASK  = 8'h02;
  localparam logic [7:0] PIN_FIXED    = 8'h0C;

  localparam int OPT_SRST_BIT = 7;
  localparam int STAT_INT_BIT = 1;
  localparam int STAT_PD_BIT  = 2;
  localparam int PIN_RDY_BIT  = 5;
endpackage

// File: rtl/pcc_attr_decode.sv
module pcc_attr_decode
  import pcc_cfg_pkg::*;
#(
  parameter int AW = 10,
  parameter logic [AW-1:0] BASE = 10'h200,
  parameter int CIS_LEN = 16
) (
  input  logic [AW-1:0] addr_i,
  output attr_sel_e     sel_o
);
  localparam logic [AW:0] CIS_LIM = (AW+1)'(CIS_LEN);

  logic [AW-1:0] off;

  always_comb begin
    off   = addr_i - BASE;
    sel_o = SEL_NONE;
    if (addr_i < BASE) begin
      if ({1'b0, addr_i} < CIS_LIM) sel_o = SEL_CIS;
    end else begin
      unique case (off)
        AW'(OFF_OPT):  sel_o = SEL_OPT;
        AW'(OFF_STAT): sel_o = SEL_STAT;
        AW'(OFF_PINS): sel_o = SEL_PINS;
        AW'(OFF_SOCK): sel_o = SEL_SOCK;
        default:       sel_o = SEL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/pcc_cfg_regs.sv
module pcc_cfg_regs
  import pcc_cfg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  attr_sel_e  sel_i,
  input  logic [7:0] wdata_i,
  input  logic       devctl_we_i,
  input  logic       devctl_nien_i,
  input  logic       devctl_srst_i,
  input  logic       drive_irq_i,
  output logic [7:0] opt_o,
  output logic [7:0] stat_o,
  output logic [7:0] pins_o,
  output logic       nien_o,
  output logic       drive_rst_o
);
  logic [7:0] opt_q, stat_q, pins_q;
  logic [7:0] opt_d, stat_d, pins_d;
  logic       nien_q, nien_d, rst_q, srst_req;

  always_comb begin
    srst_req = (we_i && sel_i == SEL_OPT && wdata_i[OPT_SRST_BIT]) ||
               (devctl_we_i && devctl_srst_i);
    opt_d  = opt_q;
    stat_d = stat_q;
    pins_d = pins_q;
    nien_d = devctl_we_i ? devctl_nien_i : nien_q;
    if (we_i) begin
      unique case (sel_i)
        SEL_OPT:  opt_d = wdata_i & OPT_WR_MASK;
        SEL_STAT: begin
          stat_d = (stat_q & STAT_KEEP) | (wdata_i & STAT_WR_MASK);
          if (stat_q[STAT_PD_BIT] != wdata_i[STAT_PD_BIT]) pins_d[PIN_RDY_BIT] = 1'b1;
        end
        SEL_PINS: pins_d = (pins_q & PIN_KEEP) | (wdata_i & PIN_WR_MASK);
        default: ;
      endcase
    end
    // drive level owns the interrupt bit, even against a status write
    stat_d[STAT_INT_BIT] = drive_irq_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      opt_q  <= '0;
      stat_q <= '0;
      pins_q <= '0;
      nien_q <= 1'b0;
      rst_q  <= 1'b0;
    end else if (srst_req) begin
      opt_q  <= '0;
      stat_q <= '0;
      pins_q <= '0;
      nien_q <= 1'b0;
      rst_q  <= 1'b1;
    end else begin
      opt_q  <= opt_d;
      stat_q <= stat_d;
      pins_q <= pins_d;
      nien_q <= nien_d;
      rst_q  <= 1'b0;
    end
  end

  assign opt_o       = opt_q;
  assign stat_o      = stat_q;
  assign pins_o      = pins_q;
  assign nien_o      = nien_q;
  assign drive_rst_o = rst_q;
endmodule

// File: rtl/pcc_attr_rdmux.sv
module pcc_attr_rdmux
  import pcc_cfg_pkg::*;
#(
  parameter int AW = 10,
  parameter int CIS_LEN = 16
) (
  input  logic [AW-1:0]        addr_i,
  input  attr_sel_e            sel_i,
  input  logic [CIS_LEN*8-1:0] cis_i,
  input  logic [7:0]           opt_i,
  input  logic [7:0]           stat_i,
  input  logic                 pin_rdy_i,
  input  logic                 nien_i,
  output logic [7:0]           rdata_o
);
  logic [7:0] cis_byte;

  always_comb begin
    cis_byte = '0;
    for (int i = 0; i < CIS_LEN; i++) begin
      if (addr_i == AW'(i)) cis_byte = cis_i[i*8 +: 8];
    end
  end

  always_comb begin
    unique case (sel_i)
      SEL_CIS:  rdata_o = cis_byte;
      SEL_OPT:  rdata_o = opt_i;
      SEL_STAT: begin
        rdata_o = stat_i;
        if (nien_i) rdata_o[STAT_INT_BIT] = 1'b0;
      end
      SEL_PINS: rdata_o = PIN_FIXED | (8'(pin_rdy_i) << PIN_RDY_BIT);
      default:  rdata_o = 8'h00;
    endcase
  end
endmodule

// File: rtl/pcc_cfg_bank.sv
module pcc_cfg_bank
  import pcc_cfg_pkg::*;
#(
  parameter int AW = 10,
  parameter logic [AW-1:0] BASE = 10'h200,
  parameter int CIS_LEN = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [AW-1:0]        attr_addr_i,
  input  logic [7:0]           attr_wdata_i,
  input  logic                 attr_we_i,
  output logic [7:0]           attr_rdata_o,
  input  logic [CIS_LEN*8-1:0] cis_rom_i,
  input  logic                 devctl_we_i,
  input  logic                 devctl_nien_i,
  input  logic                 devctl_srst_i,
  input  logic                 drive_irq_i,
  output logic                 slot_irq_o,
  output logic                 drive_rst_o
);
  attr_sel_e  sel_w;
  logic [7:0] opt_w, stat_w, pins_w;
  logic       nien_w;

  pcc_attr_decode #(.AW(AW), .BASE(BASE), .CIS_LEN(CIS_LEN)) u_dec (
    .addr_i (attr_addr_i),
    .sel_o  (sel_w)
  );

  pcc_cfg_regs u_regs (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .we_i          (attr_we_i),
    .sel_i         (sel_w),
    .wdata_i       (attr_wdata_i),
    .devctl_we_i   (devctl_we_i),
    .devctl_nien_i (devctl_nien_i),
    .devctl_srst_i (devctl_srst_i),
    .drive_irq_i   (drive_irq_i),
    .opt_o         (opt_w),
    .stat_o        (stat_w),
    .pins_o        (pins_w),
    .nien_o        (nien_w),
    .drive_rst_o   (drive_rst_o)
  );

  pcc_attr_rdmux #(.AW(AW), .CIS_LEN(CIS_LEN)) u_rd (
    .addr_i    (attr_addr_i),
    .sel_i     (sel_w),
    .cis_i     (cis_rom_i),
    .opt_i     (opt_w),
    .stat_i    (stat_w),
    .pin_rdy_i (pins_w[PIN_RDY_BIT]),
    .nien_i    (nien_w),
    .rdata_o   (attr_rdata_o)
  );

  // inverted sense: a pending drive request holds the slot line low;
  // the stored soft-reset control bit never survives, so only nien gates here
  assign slot_irq_o = !stat_w[STAT_INT_BIT] && !nien_w && !opt_w[OPT_SRST_BIT];
endmodule

// File: rtl/pcc_cfg_bank_chk.sv
module pcc_cfg_bank_chk #(
  parameter int AW = 10,
  parameter logic [AW-1:0] BASE = 10'h200
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] attr_addr_i,
  input logic [7:0]    attr_wdata_i,
  input logic          attr_we_i,
  input logic [7:0]    attr_rdata_o,
  input logic          devctl_we_i,
  input logic          devctl_nien_i,
  input logic          devctl_srst_i,
  input logic          drive_irq_i,
  input logic          slot_irq_o,
  input logic          drive_rst_o,
  input logic [7:0]    opt_i,
  input logic [7:0]    stat_i,
  input logic [7:0]    pins_i,
  input logic          nien_i
);
  logic at_opt, at_stat, at_pins, opt_wr, stat_wr, pins_wr, srst;
  assign at_opt  = attr_addr_i == BASE;
  assign at_stat = attr_addr_i == BASE + AW'(2);
  assign at_pins = attr_addr_i == BASE + AW'(4);
  assign opt_wr  = attr_we_i && at_opt;
  assign stat_wr = attr_we_i && at_stat;
  assign pins_wr = attr_we_i && at_pins;
  assign srst    = (opt_wr && attr_wdata_i[7]) || (devctl_we_i && devctl_srst_i);

  a_r3_opt_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    opt_wr && !srst |=> opt_i == ($past(attr_wdata_i) & 8'hCF));

  a_r9_soft_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst |=> opt_i == 8'h00 && stat_i == 8'h00 && pins_i == 8'h00 && !nien_i && drive_rst_o);

  a_r9_pulse_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drive_rst_o) |-> $past(srst));

  a_r5_pwrdn_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_wr && !srst && (attr_wdata_i[2] != stat_i[2]) |=> pins_i[5]);

  a_r6_pin_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pins_wr && !srst |=> pins_i[1] == $past(attr_wdata_i[1]) && pins_i[5] == $past(pins_i[5]));

  a_r6_pin_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    at_pins |-> attr_rdata_o[3:0] == 4'hC);

  a_r4_int_hidden: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nien_i && at_stat |-> !attr_rdata_o[1]);

  a_r8_irq_inverted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_irq_i && !srst |=> !slot_irq_o);

  a_r10_nien_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    devctl_we_i && !srst |=> nien_i == $past(devctl_nien_i));
endmodule

bind pcc_cfg_bank pcc_cfg_bank_chk #(.AW(AW), .BASE(BASE)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .attr_addr_i   (attr_addr_i),
  .attr_wdata_i  (attr_wdata_i),
  .attr_we_i     (attr_we_i),
  .attr_rdata_o  (attr_rdata_o),
  .devctl_we_i   (devctl_we_i),
  .devctl_nien_i (devctl_nien_i),
  .devctl_srst_i (devctl_srst_i),
  .drive_irq_i   (drive_irq_i),
  .slot_irq_o    (slot_irq_o),
  .drive_rst_o   (drive_rst_o),
  .opt_i         (opt_w),
  .stat_i        (stat_w),
  .pins_i        (pins_w),
  .nien_i        (nien_w)
);

// File: tb/pcc_cfg_bank_tb_top.sv
module pcc_cfg_bank_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;
  localparam logic [AW-1:0] BASE = 10'h200;
  localparam int CIS_LEN = 16;
  localparam logic [AW-1:0] A_OPT  = BASE;
  localparam logic [AW-1:0] A_STAT = BASE + 10'd2;
  localparam logic [AW-1:0] A_PINS = BASE + 10'd4;
  localparam logic [AW-1:0] A_SOCK = BASE + 10'd6;

  logic                 clk = 1'b0;
  logic                 rst_ni = 1'b0;
  logic [AW-1:0]        attr_addr_i = '0;
  logic [7:0]           attr_wdata_i = '0;
  logic                 attr_we_i = 1'b0;
  logic [7:0]           attr_rdata_o;
  logic [CIS_LEN*8-1:0] cis_rom_i;
  logic                 devctl_we_i = 1'b0;
  logic                 devctl_nien_i = 1'b0;
  logic                 devctl_srst_i = 1'b0;
  logic                 drive_irq_i = 1'b0;
  logic                 slot_irq_o;
  logic                 drive_rst_o;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcc_cfg_bank #(.AW(AW), .BASE(BASE), .CIS_LEN(CIS_LEN)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .attr_addr_i(attr_addr_i), .attr_wdata_i(attr_wdata_i),
    .attr_we_i(attr_we_i), .attr_rdata_o(attr_rdata_o), .cis_rom_i(cis_rom_i),
    .devctl_we_i(devctl_we_i), .devctl_nien_i(devctl_nien_i), .devctl_srst_i(devctl_srst_i),
    .drive_irq_i(drive_irq_i), .slot_irq_o(slot_irq_o), .drive_rst_o(drive_rst_o)
  );

  function automatic logic [7:0] cis_exp(int i);
    return 8'(i * 37 + 11);
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%02h exp=%02h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
    @(negedge clk);
    attr_addr_i = a;
    #1;
    d = attr_rdata_o;
  endtask

  task automatic rd_chk(string req, logic [AW-1:0] a, logic [7:0] exp);
    logic [7:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  // one edge carrying an optional attribute write and an optional device-control write
  task automatic cyc(logic awe, logic [AW-1:0] a, logic [7:0] d,
                     logic cwe, logic nien, logic srst);
    @(negedge clk);
    attr_we_i = awe; attr_addr_i = a; attr_wdata_i = d;
    devctl_we_i = cwe; devctl_nien_i = nien; devctl_srst_i = srst;
    @(negedge clk);
    attr_we_i = 1'b0; devctl_we_i = 1'b0; devctl_nien_i = 1'b0; devctl_srst_i = 1'b0;
  endtask

  task automatic wr(logic [AW-1:0] a, logic [7:0] d);
    cyc(1'b1, a, d, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic ctl(logic nien, logic srst);
    cyc(1'b0, '0, 8'h00, 1'b1, nien, srst);
  endtask

  task automatic soft_reset();
    ctl(1'b0, 1'b1);
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R9 reset opt", 8'(0), 8'(0));
    rd_chk("R9 reset opt", A_OPT, 8'h00);
    rd_chk("R9 reset stat", A_STAT, 8'h00);
    rd_chk("R9 reset pins", A_PINS, 8'h0C);
    check("R8 reset slot_irq", 8'(slot_irq_o), 8'h01);
    check("R9 reset drive_rst", 8'(drive_rst_o), 8'h00);
  endtask

  task automatic t_cis();
    rd_chk("R2 cis byte 0", 10'd0, cis_exp(0));
    rd_chk("R2 cis byte 5", 10'd5, cis_exp(5));
    rd_chk("R2 cis last byte", 10'(CIS_LEN-1), cis_exp(CIS_LEN-1));
    rd_chk("R2 past cis length", 10'(CIS_LEN), 8'h00);
    rd_chk("R2 just below base", BASE - 10'd1, 8'h00);
    wr(10'd3, 8'hEE);
    wr(BASE - 10'd1, 8'h80);
    rd_chk("R2 cis after write", 10'd3, cis_exp(3));
    rd_chk("R2 opt after low write", A_OPT, 8'h00);
  endtask

  task automatic t_opt();
    soft_reset();
    wr(A_OPT, 8'h7F);
    rd_chk("R3 opt 7F masked", A_OPT, 8'h4F);
    wr(A_OPT, 8'h35);
    rd_chk("R3 opt 35 masked", A_OPT, 8'h05);
    check("R8 slot_irq with opt set", 8'(slot_irq_o), 8'h01);
  endtask

  task automatic t_stat();
    soft_reset();
    wr(A_STAT, 8'hFF);
    rd_chk("R4 stat FF merged", A_STAT, 8'h74);
    rd_chk("R5 ready after pd toggle", A_PINS, 8'h2C);
    soft_reset();
    wr(A_STAT, 8'h8B);
    rd_chk("R4 stat 8B merged", A_STAT, 8'h00);
    wr(A_STAT, 8'h70);
    rd_chk("R4 stat 70", A_STAT, 8'h70);
    rd_chk("R5 no ready without toggle", A_PINS, 8'h0C);
    wr(A_STAT, 8'h74);
    rd_chk("R5 ready on pd set", A_PINS, 8'h2C);
  endtask

  task automatic t_pins();
    soft_reset();
    wr(A_PINS, 8'hFF);
    rd_chk("R6 pin write cannot set ready", A_PINS, 8'h0C);
    wr(A_STAT, 8'h04);
    wr(A_PINS, 8'h00);
    rd_chk("R6 ready kept over pin write", A_PINS, 8'h2C);
  endtask

  task automatic t_undef();
    soft_reset();
    wr(A_OPT, 8'h05);
    wr(A_SOCK, 8'hFF);
    wr(BASE + 10'd8, 8'hFF);
    wr(BASE + 10'd1, 8'h80);
    wr(BASE + 10'd3, 8'hFF);
    rd_chk("R7 socket reads zero", A_SOCK, 8'h00);
    rd_chk("R1 offset 8 reads zero", BASE + 10'd8, 8'h00);
    rd_chk("R1 odd offset reads zero", BASE + 10'd1, 8'h00);
    rd_chk("R1 opt untouched", A_OPT, 8'h05);
    rd_chk("R1 stat untouched", A_STAT, 8'h00);
    rd_chk("R1 pins untouched", A_PINS, 8'h0C);
    check("R1 no reset pulse", 8'(drive_rst_o), 8'h00);
  endtask

  task automatic t_irq();
    soft_reset();
    @(negedge clk); drive_irq_i = 1'b1;
    @(negedge clk);
    check("R8 drive irq drops slot line", 8'(slot_irq_o), 8'h00);
    rd_chk("R8 stat shows irq", A_STAT, 8'h02);
    ctl(1'b1, 1'b0);
    rd_chk("R4 irq hidden by nien", A_STAT, 8'h00);
    @(negedge clk); drive_irq_i = 1'b0;
    @(negedge clk);
    check("R10 nien holds slot low", 8'(slot_irq_o), 8'h00);
    ctl(1'b0, 1'b0);
    check("R10 nien cleared", 8'(slot_irq_o), 8'h01);
  endtask

  task automatic t_srst();
    soft_reset();
    wr(A_OPT, 8'h41);
    wr(A_STAT, 8'h74);
    ctl(1'b1, 1'b0);
    wr(A_OPT, 8'h80);
    check("R9 pulse after opt reset", 8'(drive_rst_o), 8'h01);
    @(negedge clk);
    check("R9 pulse one cycle", 8'(drive_rst_o), 8'h00);
    rd_chk("R9 opt cleared", A_OPT, 8'h00);
    rd_chk("R9 stat cleared", A_STAT, 8'h00);
    rd_chk("R9 pins cleared", A_PINS, 8'h0C);
    check("R9 nien cleared", 8'(slot_irq_o), 8'h01);
    wr(A_OPT, 8'h03);
    ctl(1'b1, 1'b1);
    check("R9 pulse after devctl reset", 8'(drive_rst_o), 8'h01);
    rd_chk("R9 opt cleared by devctl", A_OPT, 8'h00);
    check("R9 nien not kept", 8'(slot_irq_o), 8'h01);
  endtask

  task automatic t_collide();
    soft_reset();
    @(negedge clk);
    attr_we_i = 1'b1; attr_addr_i = A_STAT; attr_wdata_i = 8'h00; drive_irq_i = 1'b1;
    @(negedge clk);
    attr_we_i = 1'b0;
    rd_chk("R11 irq rise beats stat write", A_STAT, 8'h02);
    @(negedge clk);
    attr_we_i = 1'b1; attr_addr_i = A_STAT; attr_wdata_i = 8'h76; drive_irq_i = 1'b0;
    @(negedge clk);
    attr_we_i = 1'b0;
    rd_chk("R11 irq fall beats stat write", A_STAT, 8'h74);
    check("R11 slot line back", 8'(slot_irq_o), 8'h01);
    cyc(1'b1, A_OPT, 8'h41, 1'b1, 1'b1, 1'b0);
    check("R11 both writes, nien gates", 8'(slot_irq_o), 8'h00);
    rd_chk("R11 both writes, opt kept", A_OPT, 8'h41);
    cyc(1'b1, A_OPT, 8'h01, 1'b1, 1'b0, 1'b1);
    check("R11 reset wins pulse", 8'(drive_rst_o), 8'h01);
    rd_chk("R11 reset wins opt", A_OPT, 8'h00);
  endtask

  task automatic finish_up();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < CIS_LEN; i++) cis_rom_i[i*8 +: 8] = cis_exp(i);
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=%02h exp=%02h", 8'h00, 8'h01);
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_cis();
    t_opt();
    t_stat();
    t_pins();
    t_undef();
    t_irq();
    t_srst();
    t_collide();
    finish_up();
  end
endmodule